// File: doc/BRIEF.md
# Programmable-Range Reloading Up Counter

This block counts upward through a fixed window of values chosen at build time. It is built from a 4-bit synchronous binary counter. That counter has a count enable, a synchronous parallel load, an active-low asynchronous clear and a cascade carry. A small detector watches for the last value of the window, called the terminal value. The counter steps up by one on every enabled clock. When it sits on the terminal value with enable high, the next clock loads the first value of the window, called the start value. This gives a modulus of TERM − START + 1, and the window may be offset from zero, for example 9 up to 14.

The wrap is always a synchronous load. The counter never clears asynchronously on an illegal count, so no short-lived extra state appears at the output. A synchronous reset presets the start value. The asynchronous clear of the inner counter is tied inactive inside the wrapper.

All pins are plain control and status signals. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `term_reload_counter`

## Requirements
- R1: When `rst` is 1 at a rising clock edge, `count` becomes START on that edge, whatever `en` is and whatever the current count is.
- R2: When `rst` is 0 and `en` is 0, `count` keeps its value across the edge.
- R3: When `rst` is 0, `en` is 1 and `count` differs from TERM, `count` increases by exactly one on the edge.
- R4: When `rst` is 0, `en` is 1 and `count` equals TERM, the next edge loads START into `count`.
- R5: `tc` is 1 exactly while `count` equals TERM and `en` is 1. It follows `en` combinationally and is 0 at the terminal value while `en` is 0.
- R6: `carry` is 1 exactly while all four count bits are 1 and `en` is 1.
- R7: A count outside the START..TERM window still advances by one per enabled clock. From 15 it wraps to 0 and keeps counting until it reaches TERM, where R4 applies.
- R8: Built with START=0 and TERM=6, enabled counting from reset gives 0,1,2,3,4,5,6,0,… with period 7.
- R9: Built with START=9 and TERM=14, enabled counting from reset gives 9,10,11,12,13,14,9,… with period 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous preset to START, active high, highest priority |
| en | input | 1 | Count enable |
| count | output | W (4) | Present count |
| carry | output | 1 | All count bits 1 while enabled, for cascading |
| tc | output | 1 | Terminal value reached while enabled |

## Verification
The bench builds three copies of the block side by side on shared `rst` and `en`:
- **START=9, TERM=14** is the offset window. It is walked through a vector table covering hold, step, reload and reset under both enable levels.
- **START=0, TERM=6** is the modulo-7 window.
- **START=12, TERM=2** has a start value above the terminal value. This is the only configuration that reaches 15 from a normal reset. It therefore brings the `carry` output, the wrap from 15 to 0 and the out-of-window advance of R7 within reach of the ports.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int unsigned CNT_W = 4;
endpackage

// File: rtl/tog_counter.sv
module tog_counter #(
  parameter int unsigned W = trc_pkg::CNT_W
) (
  input  logic         clk,
  input  logic         aclr_n,
  input  logic         en,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         co
);
  // toggle chain: bit i flips when enable and all lower bits are 1
  logic [W:0]   tgl;
  logic [W-1:0] nxt;

  assign tgl[0] = en;
  generate
    for (genvar i = 0; i < W; i++) begin : g_chain
      assign tgl[i+1] = tgl[i] & q[i];
    end
  endgenerate

  always_comb begin
    if (ld) nxt = d;
    else    nxt = q ^ tgl[W-1:0];
  end

  always_ff @(posedge clk or negedge aclr_n) begin
    if (!aclr_n) q <= '0;
    else         q <= nxt;
  end

  assign co = tgl[W];

  p_hold_r2: assert property (@(posedge clk) disable iff (!aclr_n)
    (!ld && !en) |=> $stable(q));
  p_step_r3: assert property (@(posedge clk) disable iff (!aclr_n)
    (!ld && en) |=> (q == W'($past(q) + 1'b1)));
  p_load_r4: assert property (@(posedge clk) disable iff (!aclr_n)
    ld |=> (q == $past(d)));
endmodule

// File: rtl/term_detect.sv
module term_detect #(
  parameter int unsigned W    = trc_pkg::CNT_W,
  parameter int unsigned TERM = 14
) (
  input  logic [W-1:0] cnt,
  input  logic         en,
  output logic         hit
);
  localparam logic [W-1:0] TERM_V = TERM[W-1:0];
  assign hit = (cnt == TERM_V) && en;
endmodule

// File: rtl/term_reload_counter.sv
module term_reload_counter #(
  parameter int unsigned W     = trc_pkg::CNT_W,
  parameter int unsigned START = 9,
  parameter int unsigned TERM  = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] count,
  output logic         carry,
  output logic         tc
);
  localparam logic [W-1:0] START_V = START[W-1:0];
  localparam logic [W-1:0] ALL1    = {W{1'b1}};

  logic ld;

  term_detect #(.W(W), .TERM(TERM)) i_det (
    .cnt (count),
    .en  (en),
    .hit (tc)
  );

  // reset and terminal reload share the synchronous load path
  assign ld = rst | tc;

  tog_counter #(.W(W)) i_cnt (
    .clk    (clk),
    .aclr_n (1'b1),
    .en     (en),
    .ld     (ld),
    .d      (START_V),
    .q      (count),
    .co     (carry)
  );

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (count == START_V));
  p_reload_r4: assert property (@(posedge clk) disable iff (rst)
    tc |=> (count == START_V));
  p_carry_r6: assert property (@(posedge clk) disable iff (rst)
    carry |-> (count == ALL1 && en));
  p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (en && !tc && count == ALL1) |=> (count == '0));
endmodule

// File: tb/test_term_reload_counter.sv
module test_term_reload_counter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  int   errors = 0;
  int   checks = 0;

  always #10 clk = ~clk;

  logic [3:0] ca, cb, cc;
  logic       tca, tcb, tcc, cya, cyb, cyc;

  term_reload_counter #(.START(9), .TERM(14)) i_term_reload_counter (
    .clk(clk), .rst(rst), .en(en), .count(ca), .carry(cya), .tc(tca));
  term_reload_counter #(.START(0), .TERM(6)) i_mod7 (
    .clk(clk), .rst(rst), .en(en), .count(cb), .carry(cyb), .tc(tcb));
  term_reload_counter #(.START(12), .TERM(2)) i_wrap (
    .clk(clk), .rst(rst), .en(en), .count(cc), .carry(cyc), .tc(tcc));

  // {rst, en, count_after_edge[3:0], tc, carry} for the 9..14 copy
  localparam logic [7:0] VEC [13] = '{
    8'b11_1001_0_0, // R1 reset
    8'b01_1010_0_0, // R3
    8'b00_1010_0_0, // R2 hold
    8'b01_1011_0_0,
    8'b01_1100_0_0,
    8'b01_1101_0_0,
    8'b01_1110_1_0, // R5 tc at terminal
    8'b00_1110_0_0, // R5 tc low while disabled, R2
    8'b01_1001_0_0, // R4 reload
    8'b01_1010_0_0,
    8'b10_1001_0_0, // R1 reset with en low
    8'b01_1010_0_0,
    8'b11_1001_0_0  // R1 reset mid-count
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nxt(input bit r, input bit e, input int c,
                             input int s, input int t);
    if (r) return s;
    if (!e) return c;
    if (c == t) return s;
    return (c + 1) % 16;
  endfunction

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int mb, mc;
    int seq9 [8] = '{9, 10, 11, 12, 13, 14, 9, 10};
    foreach (VEC[i]) begin
      @(negedge clk);
      rst = VEC[i][7];
      en  = VEC[i][6];
      @(posedge clk); #1;
      chk("R1-R4 count", ca, VEC[i][5:2]);
      chk("R5 tc", tca, VEC[i][1]);
      chk("R6 carry", cya, VEC[i][0]);
    end

    // R9 and R8: free run from reset
    @(negedge clk); rst = 1'b1; en = 1'b1;
    @(posedge clk); #1;
    mb = 0; mc = 12;
    chk("R9 start", ca, 9);
    chk("R8 start", cb, 0);
    chk("R1 wrap copy start", cc, 12);
    @(negedge clk); rst = 1'b0;
    for (int k = 0; k < 16; k++) begin
      // combinational flags for current state, before the edge
      chk("R5 tc mod7", tcb, (mb == 6) ? 1 : 0);
      chk("R6 carry wrap copy", cyc, (mc == 15) ? 1 : 0);
      chk("R6 carry mod7", cyb, 0);
      mb = nxt(1'b0, 1'b1, mb, 0, 6);
      mc = nxt(1'b0, 1'b1, mc, 12, 2);
      @(posedge clk); #1;
      chk("R8 sequence", cb, mb);
      chk("R7 out-of-window advance", cc, mc);
      if (k < 7) chk("R9 sequence", ca, seq9[k + 1]);
      @(negedge clk);
    end

    // R5: tc follows en combinationally at terminal
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int k = 0; k < 6; k++) @(negedge clk); // mod7 copy now at 6
    chk("R5 tc with en high", tcb, 1);
    en = 1'b0; #1;
    chk("R5 tc with en low", tcb, 0);
    chk("R2 hold at terminal", cb, 6);
    @(posedge clk); #1;
    chk("R2 hold after edge", cb, 6);
    @(negedge clk); en = 1'b1;
    @(posedge clk); #1;
    chk("R4 mod7 reload", cb, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule